// File: doc/BRIEF.md
# GPIO Interrupt Sense Controller

This block turns a vector of already-synchronized GPIO input lines into interrupt status. Each line is set up on its own to react to a steady level or to a transition. A level can be active-high or active-low. A transition can be a rising edge, a falling edge, or both edges. Transition events are held in a status bit until software acknowledges them. Level conditions are not held: they appear while the input sits at the active level and disappear as soon as it leaves that level.

Software programs and inspects the block over a byte-wide, two-phase, APB-style register bus. The raw status shows every pending condition. The masked status shows only the lines that are enabled. The OR of all masked bits drives one registered interrupt line toward the system interrupt controller.

Top module: `gpio_irq_sense`

## Requirements
- R1: After reset, the mode, both-edge, polarity and enable registers read 0, the raw and masked status read 0, and `irq_out` is 0.
- R2: A line in edge mode (mode bit 0, both-edge bit 0) with polarity bit 1 sets its raw status bit on a 0-to-1 change of its input. Status is set one clock after the change is sampled.
- R3: A line in edge mode with polarity bit 0 sets its raw status bit on a 1-to-0 change of its input, and a 0-to-1 change leaves the bit unchanged.
- R4: With its both-edge bit at 1, an edge-mode line sets its raw status on either a rising or a falling change, and its polarity bit has no effect.
- R5: A line with mode bit 1 is level sensed: its raw status is 1 exactly while the input equals its polarity bit (1 = active high, 0 = active low). It clears when the level ends, with no acknowledge, and a level-mode line never latches an edge.
- R6: Writing the clear register (offset 0x18) with bit n at 1 clears the latched edge status of line n. A 0 bit leaves that line's status unchanged.
- R7: When an edge is detected on a line in the same clock as a clear write for that line, the status bit ends up set.
- R8: Masked status (offset 0x14) equals raw status AND enable. `irq_out` is the OR of the masked bits, registered, so it changes one clock after the masked status changes.
- R9: A write to the mode register that changes bit n clears any edge status latched for line n.
- R10: Register offsets are: mode 0x00 (1 = level, 0 = edge), both-edge 0x04, polarity 0x08, enable 0x0C, raw status 0x10 and masked status 0x14 (both read-only), and clear 0x18 (write-only, reads 0). The configuration registers read back what was written, and writes to the read-only offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register bus select (setup and access phases) |
| bus_en | input | 1 | Register bus access phase strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 8 | Write data, one bit per line |
| bus_rdata | output | 8 | Read data, valid while `bus_sel` is high and `bus_wr` is low |
| pins_sync | input | 8 | Synchronized GPIO input lines |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Each detection mode is driven with rising pulses, falling pulses and steady levels. This separates rising-only, falling-only and both-edge lines, and shows that a line ignores the transition it is not set for. Level lines are moved into and out of their active level without any acknowledge, which tells held status apart from status that only follows the input. Clear writes are tried with ones and with zeros, alone and in the same clock as a new edge. Mode round trips show whether old edge state survives a change of mode. Enable patterns, together with sampling `irq_out` on each side of the register stage, show the masking and the one-clock latency.

// File: rtl/gis_pkg.sv
package gis_pkg;
  localparam int OFF_W = 5;
  localparam logic [OFF_W-1:0] OFF_MODE  = 5'h00;
  localparam logic [OFF_W-1:0] OFF_BOTH  = 5'h04;
  localparam logic [OFF_W-1:0] OFF_POL   = 5'h08;
  localparam logic [OFF_W-1:0] OFF_ENA   = 5'h0C;
  localparam logic [OFF_W-1:0] OFF_RAW   = 5'h10;
  localparam logic [OFF_W-1:0] OFF_MASK  = 5'h14;
  localparam logic [OFF_W-1:0] OFF_CLR   = 5'h18;

  // Edge event for one line in edge mode.
  function automatic logic line_edge(input logic lvl_mode, input logic both,
                                     input logic pol, input logic cur,
                                     input logic prev);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    if (lvl_mode) return 1'b0;
    if (both) return rise | fall;
    return pol ? rise : fall;
  endfunction

  // Active level for one line in level mode.
  function automatic logic line_level(input logic lvl_mode, input logic pol,
                                      input logic cur);
    return lvl_mode & (cur == pol);
  endfunction
endpackage

// File: rtl/gis_regs.sv
module gis_regs #(
  parameter int N  = 8,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_en,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [N-1:0]  bus_wdata,
  output logic [N-1:0]  bus_rdata,
  input  logic [N-1:0]  raw_i,
  input  logic [N-1:0]  masked_i,
  output logic [N-1:0]  mode_o,
  output logic [N-1:0]  both_o,
  output logic [N-1:0]  pol_o,
  output logic [N-1:0]  ena_o,
  output logic [N-1:0]  clr_o,
  output logic [N-1:0]  mode_chg_o
);
  import gis_pkg::*;

  logic [N-1:0] mode_q, both_q, pol_q, ena_q;
  logic         wr_fire;
  logic         wr_ro;

  assign wr_fire = bus_sel & bus_en & bus_wr;
  assign wr_ro   = wr_fire && (bus_addr == AW'(OFF_RAW) || bus_addr == AW'(OFF_MASK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      both_q <= '0;
      pol_q  <= '0;
      ena_q  <= '0;
    end else if (wr_fire) begin
      if (bus_addr == AW'(OFF_MODE)) mode_q <= bus_wdata;
      if (bus_addr == AW'(OFF_BOTH)) both_q <= bus_wdata;
      if (bus_addr == AW'(OFF_POL))  pol_q  <= bus_wdata;
      if (bus_addr == AW'(OFF_ENA))  ena_q  <= bus_wdata;
    end
  end

  // Strobes toward the detector: acknowledge mask and mode-change mask.
  assign clr_o      = (wr_fire && bus_addr == AW'(OFF_CLR)) ? bus_wdata : '0;
  assign mode_chg_o = (wr_fire && bus_addr == AW'(OFF_MODE)) ? (bus_wdata ^ mode_q) : '0;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        AW'(OFF_MODE): bus_rdata = mode_q;
        AW'(OFF_BOTH): bus_rdata = both_q;
        AW'(OFF_POL):  bus_rdata = pol_q;
        AW'(OFF_ENA):  bus_rdata = ena_q;
        AW'(OFF_RAW):  bus_rdata = raw_i;
        AW'(OFF_MASK): bus_rdata = masked_i;
        default:       bus_rdata = '0;
      endcase
    end
  end

  assign mode_o = mode_q;
  assign both_o = both_q;
  assign pol_o  = pol_q;
  assign ena_o  = ena_q;

  // R10: writes to read-only status offsets leave the configuration untouched
  assert_ro_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ro |=> $stable({mode_q, both_q, pol_q, ena_q}));
endmodule

// File: rtl/gis_detect.sv
module gis_detect #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pins_i,
  input  logic [N-1:0] mode_i,
  input  logic [N-1:0] both_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] mode_chg_i,
  output logic [N-1:0] raw_o
);
  import gis_pkg::*;

  logic [N-1:0] prev_q;
  logic [N-1:0] edge_q;
  logic [N-1:0] hit;
  logic [N-1:0] lvl;
  logic [N-1:0] hit_kept;
  logic [N-1:0] clr_eff;

  for (genvar g = 0; g < N; g++) begin : g_line
    assign hit[g] = line_edge(mode_i[g], both_i[g], pol_i[g], pins_i[g], prev_q[g]);
    assign lvl[g] = line_level(mode_i[g], pol_i[g], pins_i[g]);
  end

  // A new edge outranks an acknowledge; a mode change outranks both.
  assign hit_kept = hit & ~mode_chg_i;
  assign clr_eff  = clr_i & ~hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      edge_q <= '0;
    end else begin
      prev_q <= pins_i;
      edge_q <= ((edge_q & ~clr_i) | hit) & ~mode_chg_i;
    end
  end

  assign raw_o = lvl | edge_q;

  // R5: level-sensed lines never hold latched edge status
  assert_level_unlatched_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_q & mode_i) == '0);

  // R6: an acknowledged line with no fresh edge is cleared next cycle
  assert_clear_takes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_eff & ~mode_chg_i) != '0 |=> (edge_q & $past(clr_eff & ~mode_chg_i)) == '0);

  // R7: a detected edge is held next cycle, even against a clear
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_kept != '0 |=> (edge_q & $past(hit_kept)) == $past(hit_kept));

  // R9: a mode change drops latched edge state for that line
  assert_mode_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg_i != '0 |=> (edge_q & $past(mode_chg_i)) == '0);
endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense #(
  parameter int N  = 8,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_en,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [N-1:0]  bus_wdata,
  output logic [N-1:0]  bus_rdata,
  input  logic [N-1:0]  pins_sync,
  output logic          irq_out
);
  logic [N-1:0] mode, both, pol, ena, clr, mode_chg;
  logic [N-1:0] raw, masked;
  logic         irq_q;

  gis_regs #(.N(N), .AW(AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_en     (bus_en),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .raw_i      (raw),
    .masked_i   (masked),
    .mode_o     (mode),
    .both_o     (both),
    .pol_o      (pol),
    .ena_o      (ena),
    .clr_o      (clr),
    .mode_chg_o (mode_chg)
  );

  gis_detect #(.N(N)) u_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .pins_i     (pins_sync),
    .mode_i     (mode),
    .both_i     (both),
    .pol_i      (pol),
    .clr_i      (clr),
    .mode_chg_i (mode_chg),
    .raw_o      (raw)
  );

  assign masked = raw & ena;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |masked;
  end

  assign irq_out = irq_q;

  // R8: the request only rises after some enabled line was pending
  assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(masked) != '0);

  // R8: a disabled line never reaches the masked status
  assert_mask_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ena == '0 |-> masked == '0);
endmodule

// File: tb/gpio_irq_sense_bench.sv
module gpio_irq_sense_bench;
  localparam int N = 8;
  localparam int AW = 5;
  localparam logic [AW-1:0] A_MODE = 5'h00, A_BOTH = 5'h04, A_POL = 5'h08,
                            A_ENA = 5'h0C, A_RAW = 5'h10, A_MASK = 5'h14, A_CLR = 5'h18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_en = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [N-1:0]  bus_wdata = '0;
  logic [N-1:0]  bus_rdata;
  logic [N-1:0]  pins = '0;
  logic          irq_out;

  always #5 clk = ~clk;

  gpio_irq_sense #(.N(N), .AW(AW)) u_gpio_irq_sense (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pins_sync(pins), .irq_out(irq_out)
  );

  typedef struct {
    string      req;
    string      what;
    logic [7:0] val;
  } exp_t;

  exp_t       exp_q[$];
  logic [7:0] got_q[$];
  event       got_ev;
  int         n_checks = 0;
  int         n_fail = 0;
  bit         done = 0;

  // Monitor: pops expected and observed items in order and compares.
  task automatic drain();
    while (exp_q.size() > 0 && got_q.size() > 0) begin
      exp_t       e;
      logic [7:0] a;
      e = exp_q.pop_front();
      a = got_q.pop_front();
      n_checks++;
      if (a !== e.val) begin
        n_fail++;
        $display("FAIL %s %s: actual %02h expected %02h", e.req, e.what, a, e.val);
      end
    end
  endtask

  initial forever begin
    @(got_ev);
    drain();
  end

  task automatic push_exp(string req, string what, logic [7:0] v);
    exp_t e;
    e.req = req; e.what = what; e.val = v;
    exp_q.push_back(e);
  endtask

  task automatic bus_write(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_en = 0;
    @(negedge clk); bus_en = 1;
    @(negedge clk); bus_sel = 0; bus_en = 0; bus_wr = 0;
  endtask

  task automatic bus_write_pins(logic [AW-1:0] a, logic [7:0] d, logic [7:0] p);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_en = 0;
    @(negedge clk); bus_en = 1; pins = p;
    @(negedge clk); bus_sel = 0; bus_en = 0; bus_wr = 0;
  endtask

  task automatic expect_reg(string req, logic [AW-1:0] a, logic [7:0] v);
    push_exp(req, $sformatf("reg@%02h", a), v);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a; bus_en = 0;
    @(negedge clk); bus_en = 1;
    #1 got_q.push_back(bus_rdata);
    ->got_ev;
    @(negedge clk); bus_sel = 0; bus_en = 0;
  endtask

  task automatic expect_irq(string req, logic v);
    push_exp(req, "irq_out", {7'b0, v});
    #1 got_q.push_back({7'b0, irq_out});
    ->got_ev;
  endtask

  task automatic drive_pins(logic [7:0] p);
    @(negedge clk); pins = p;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    drain();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    expect_irq("R1", 1'b0);
    expect_reg("R1", A_MODE, 8'h00);
    expect_reg("R1", A_BOTH, 8'h00);
    expect_reg("R1", A_POL, 8'h00);
    expect_reg("R1", A_ENA, 8'h00);
    expect_reg("R1", A_RAW, 8'h00);
    expect_reg("R1", A_MASK, 8'h00);

    // R10: readback and read-only offsets
    bus_write(A_POL, 8'h21);
    expect_reg("R10", A_POL, 8'h21);
    bus_write(A_RAW, 8'hFF);
    bus_write(A_MASK, 8'hFF);
    expect_reg("R10", A_RAW, 8'h00);
    expect_reg("R10", A_POL, 8'h21);
    expect_reg("R10", A_CLR, 8'h00);

    // R2: rising edge on line 0
    drive_pins(8'h01);
    expect_reg("R2", A_RAW, 8'h01);
    // R3: line 4 falling-only ignores rise, latches fall
    drive_pins(8'h11);
    expect_reg("R3", A_RAW, 8'h01);
    drive_pins(8'h01);
    expect_reg("R3", A_RAW, 8'h11);

    // R6: write-one clears, zero leaves alone
    bus_write(A_CLR, 8'h01);
    expect_reg("R6", A_RAW, 8'h10);
    bus_write(A_CLR, 8'h00);
    expect_reg("R6", A_RAW, 8'h10);

    // R8: masking and registered request
    expect_irq("R8", 1'b0);
    expect_reg("R8", A_MASK, 8'h00);
    bus_write(A_ENA, 8'h10);
    expect_irq("R8", 1'b0);
    @(negedge clk);
    expect_irq("R8", 1'b1);
    expect_reg("R8", A_MASK, 8'h10);
    bus_write(A_CLR, 8'h10);
    expect_irq("R8", 1'b1);
    @(negedge clk);
    expect_irq("R8", 1'b0);
    bus_write(A_ENA, 8'h00);

    // R4: both edges on line 1, polarity 0 ignored
    bus_write(A_BOTH, 8'h02);
    drive_pins(8'h03);
    expect_reg("R4", A_RAW, 8'h02);
    bus_write(A_CLR, 8'h02);
    expect_reg("R4", A_RAW, 8'h00);
    drive_pins(8'h01);
    expect_reg("R4", A_RAW, 8'h02);
    bus_write(A_CLR, 8'h02);

    // R5: line 2 level high, line 3 level low
    bus_write(A_POL, 8'h25);
    bus_write(A_MODE, 8'h0C);
    expect_reg("R5", A_RAW, 8'h08);
    drive_pins(8'h05);
    expect_reg("R5", A_RAW, 8'h0C);
    drive_pins(8'h0D);
    expect_reg("R5", A_RAW, 8'h04);
    drive_pins(8'h01);
    expect_reg("R5", A_RAW, 8'h08);
    bus_write(A_MODE, 8'h00);
    expect_reg("R5", A_RAW, 8'h00);

    // R9: mode round trip drops latched edge on line 5
    drive_pins(8'h21);
    expect_reg("R9", A_RAW, 8'h20);
    bus_write(A_MODE, 8'h20);
    bus_write(A_MODE, 8'h00);
    expect_reg("R9", A_RAW, 8'h00);
    drive_pins(8'h01);
    expect_reg("R9", A_RAW, 8'h00);

    // R7: edge in the same clock as its clear
    drive_pins(8'h00);
    expect_reg("R7", A_RAW, 8'h00);
    bus_write_pins(A_CLR, 8'h01, 8'h01);
    expect_reg("R7", A_RAW, 8'h01);
    bus_write(A_CLR, 8'h01);
    expect_reg("R7", A_RAW, 8'h00);

    done = 1;
    @(negedge clk);
    finish_run();
  end
endmodule